// File: doc/BRIEF.md
# Destination Ring Consumer Pointer Tracker

This block keeps the consumer-side bookkeeping for one descriptor ring whose producer is hardware. It holds two word offsets into the ring: the tail, where the consumer reads next, and a cached copy of the producer's head. Both offsets wrap at a configured ring size, and that size need not be a power of two. Entries are a configured number of words wide. The entry address the block reports is the configured base plus the offset in words.

Software or a sequencer drives the block through a small command port. First it opens an access session, which samples the hardware head. Within the session it may take the next entry, look at it without consuming it, take entries by moving the cached head instead of the tail, or ask how many entries are waiting. The count can first reload the head from hardware. Closing the session publishes the tail. A flag bit in the ring configuration selects where the tail goes: a register write port, or a shared-memory pointer slot that firmware reads.

Top module: `ring_consumer_tracker`

## Requirements
- R1: In the cycle after reset, every output is 0 and no session is open. Both offsets are 0.
- R2: A configuration pulse (`cfg_valid_i`) takes priority over any command in the same cycle. It loads the ring size, entry size, base and flags, sets tail and cached head to 0, and closes the session. Entry size must be at least 1 and no more than ring size.
- R3: Op 0 (open) copies `hw_head_i` into the cached head and opens a session. It is accepted whether or not a session is open.
- R4: Op 1 (get-next), when tail differs from cached head, returns address base+tail with null clear. It then advances the tail by entry size, subtracting the ring size once the sum reaches it. When tail equals cached head, it returns null with address 0 and the tail does not move.
- R5: Op 2 (peek) reports the same address or null that op 1 would, and leaves the tail unchanged.
- R6: Op 3 (head-advancing take) forms next = cached head + entry size, wrapped. If next differs from the tail, it returns base + the old cached head and stores next as the cached head. Otherwise it returns null and nothing moves.
- R7: Op 4 (count) reports (head−tail)/entry_size when head ≥ tail, and (ring_size−tail+head)/entry_size otherwise. When `cmd_sync_i` is 1, the cached head is first reloaded from `hw_head_i`, and that new value is used in the count and kept.
- R8: Op 5 (close) drives `wb_tail_o` with the tail and ends the session. If bit 31 of the ring flags is set, `mem_wr_en_o` pulses; otherwise `reg_wr_en_o` pulses. The two never pulse together.
- R9: Any command other than op 0 issued while no session is open is ignored and `err_o` pulses for one cycle. Ops 6 and 7 inside a session have no effect.
- R10: All outputs are registered and appear in the cycle after the command. `rsp_valid_o` pulses only for accepted ops 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid_i | input | 1 | Load ring configuration |
| cfg_ring_size_i | input | PW | Ring size in words |
| cfg_entry_size_i | input | PW | Entry size in words |
| cfg_base_i | input | AW | Ring base word address |
| cfg_flags_i | input | 32 | Ring flags; bit 31 selects shared-memory write-back |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (0 open, 1 get, 2 peek, 3 head take, 4 count, 5 close) |
| cmd_sync_i | input | 1 | Count reloads head from hardware first |
| hw_head_i | input | PW | Hardware producer head offset |
| rsp_valid_o | output | 1 | Response for ops 1 to 4 |
| rsp_null_o | output | 1 | No entry available |
| rsp_addr_o | output | AW | Entry word address |
| rsp_count_o | output | PW | Valid entry count |
| err_o | output | 1 | Command issued outside a session |
| reg_wr_en_o | output | 1 | Tail write to register port |
| mem_wr_en_o | output | 1 | Tail write to shared-memory slot |
| wb_tail_o | output | PW | Published tail value |

## Verification
The embedded assertions check four things on every cycle: the two write-back strobes are exclusive and fire only after a close, the tail stays inside the ring, a peek never moves it, and an error pulse only follows a command issued while no session was open. The bench's scenarios cover the arithmetic: wrap at a ring size that is not a power of two, the empty and full stop conditions for both consume variants, the two branches of the count with and without resync, and the write-back path chosen by the flag.

// File: rtl/rct_pkg.sv
package rct_pkg;

    localparam int PTR_W      = 16;
    localparam int ADDR_W     = 32;
    localparam int FLAG_W     = 32;
    localparam int FW_FLAG_IX = 31;

    typedef enum logic [2:0] {
        OP_OPEN  = 3'd0,
        OP_GET   = 3'd1,
        OP_PEEK  = 3'd2,
        OP_HTAKE = 3'd3,
        OP_COUNT = 3'd4,
        OP_CLOSE = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } rct_op_e;

    typedef enum logic {
        WB_REG = 1'b0,
        WB_MEM = 1'b1
    } rct_wb_e;

    function automatic rct_wb_e wb_path(input logic [FLAG_W-1:0] flags);
        return flags[FW_FLAG_IX] ? WB_MEM : WB_REG;
    endfunction

endpackage

// File: rtl/rct_wrap_step.sv
module rct_wrap_step #(
    parameter int PW = rct_pkg::PTR_W
) (
    input  logic [PW-1:0] cur_i,
    input  logic [PW-1:0] step_i,
    input  logic [PW-1:0] size_i,
    output logic [PW-1:0] nxt_o
);
    localparam int SW = PW + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum = {1'b0, cur_i} + {1'b0, step_i};
        if (sum >= {1'b0, size_i}) begin
            sum = sum - {1'b0, size_i};
        end
        nxt_o = sum[PW-1:0];
    end
endmodule

// File: rtl/rct_occupancy.sv
module rct_occupancy #(
    parameter int PW = rct_pkg::PTR_W
) (
    input  logic [PW-1:0] head_i,
    input  logic [PW-1:0] tail_i,
    input  logic [PW-1:0] size_i,
    input  logic [PW-1:0] step_i,
    output logic [PW-1:0] count_o
);
    logic [PW-1:0] span;

    always_comb begin
        if (head_i >= tail_i) begin
            span = head_i - tail_i;
        end else begin
            span = size_i - tail_i + head_i;
        end
        if (step_i == '0) begin
            count_o = '0;
        end else begin
            count_o = span / step_i;
        end
    end
endmodule

// File: rtl/rct_session.sv
module rct_session
    import rct_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_valid_i,
    input  logic    cmd_valid_i,
    input  rct_op_e op_i,
    output logic    open_o,
    output logic    accept_o,
    output logic    err_o
);
    logic open_q;
    logic err_q;

    assign accept_o = cmd_valid_i && !cfg_valid_i && (open_q || op_i == OP_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= cmd_valid_i && !cfg_valid_i && !open_q && (op_i != OP_OPEN);
            if (cfg_valid_i) begin
                open_q <= 1'b0;
            end else if (accept_o && op_i == OP_OPEN) begin
                open_q <= 1'b1;
            end else if (accept_o && op_i == OP_CLOSE) begin
                open_q <= 1'b0;
            end
        end
    end

    assign open_o = open_q;
    assign err_o  = err_q;

    // R9
    err_only_closed_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (!$past(open_q) && $past(cmd_valid_i)));

endmodule

// File: rtl/ring_consumer_tracker.sv
module ring_consumer_tracker
    import rct_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid_i,
    input  logic [PW-1:0]     cfg_ring_size_i,
    input  logic [PW-1:0]     cfg_entry_size_i,
    input  logic [AW-1:0]     cfg_base_i,
    input  logic [FLAG_W-1:0] cfg_flags_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic              cmd_sync_i,
    input  logic [PW-1:0]     hw_head_i,
    output logic              rsp_valid_o,
    output logic              rsp_null_o,
    output logic [AW-1:0]     rsp_addr_o,
    output logic [PW-1:0]     rsp_count_o,
    output logic              err_o,
    output logic              reg_wr_en_o,
    output logic              mem_wr_en_o,
    output logic [PW-1:0]     wb_tail_o
);
    localparam int NSTEP = 2;

    rct_op_e       op;
    logic [PW-1:0] tail_q, chead_q, rsize_q, esize_q;
    logic [AW-1:0] base_q;
    rct_wb_e       path_q;
    logic          open_s, accept_s;

    logic [PW-1:0] step_cur [NSTEP];
    logic [PW-1:0] step_nxt [NSTEP];
    logic [PW-1:0] occ_head, occ_cnt;

    assign op = rct_op_e'(cmd_op_i);

    rct_session u_sess (
        .clk         (clk),
        .rst         (rst),
        .cfg_valid_i (cfg_valid_i),
        .cmd_valid_i (cmd_valid_i),
        .op_i        (op),
        .open_o      (open_s),
        .accept_o    (accept_s),
        .err_o       (err_o)
    );

    assign step_cur[0] = tail_q;
    assign step_cur[1] = chead_q;

    for (genvar gi = 0; gi < NSTEP; gi++) begin : g_step
        rct_wrap_step #(.PW(PW)) u_step (
            .cur_i  (step_cur[gi]),
            .step_i (esize_q),
            .size_i (rsize_q),
            .nxt_o  (step_nxt[gi])
        );
    end

    assign occ_head = cmd_sync_i ? hw_head_i : chead_q;

    rct_occupancy #(.PW(PW)) u_occ (
        .head_i  (occ_head),
        .tail_i  (tail_q),
        .size_i  (rsize_q),
        .step_i  (esize_q),
        .count_o (occ_cnt)
    );

    function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] b, input logic [PW-1:0] off);
        return b + AW'(off);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q      <= '0;
            chead_q     <= '0;
            rsize_q     <= '0;
            esize_q     <= '0;
            base_q      <= '0;
            path_q      <= WB_REG;
            rsp_valid_o <= 1'b0;
            rsp_null_o  <= 1'b0;
            rsp_addr_o  <= '0;
            rsp_count_o <= '0;
            reg_wr_en_o <= 1'b0;
            mem_wr_en_o <= 1'b0;
            wb_tail_o   <= '0;
        end else begin
            rsp_valid_o <= 1'b0;
            rsp_null_o  <= 1'b0;
            rsp_addr_o  <= '0;
            reg_wr_en_o <= 1'b0;
            mem_wr_en_o <= 1'b0;
            if (cfg_valid_i) begin
                rsize_q <= cfg_ring_size_i;
                esize_q <= cfg_entry_size_i;
                base_q  <= cfg_base_i;
                path_q  <= wb_path(cfg_flags_i);
                tail_q  <= '0;
                chead_q <= '0;
            end else if (accept_s) begin
                unique case (op)
                    OP_OPEN: begin
                        chead_q <= hw_head_i;
                    end
                    OP_GET: begin
                        rsp_valid_o <= 1'b1;
                        if (tail_q != chead_q) begin
                            rsp_addr_o <= word_addr(base_q, tail_q);
                            tail_q     <= step_nxt[0];
                        end else begin
                            rsp_null_o <= 1'b1;
                        end
                    end
                    OP_PEEK: begin
                        rsp_valid_o <= 1'b1;
                        if (tail_q != chead_q) begin
                            rsp_addr_o <= word_addr(base_q, tail_q);
                        end else begin
                            rsp_null_o <= 1'b1;
                        end
                    end
                    OP_HTAKE: begin
                        rsp_valid_o <= 1'b1;
                        if (step_nxt[1] != tail_q) begin
                            rsp_addr_o <= word_addr(base_q, chead_q);
                            chead_q    <= step_nxt[1];
                        end else begin
                            rsp_null_o <= 1'b1;
                        end
                    end
                    OP_COUNT: begin
                        rsp_valid_o <= 1'b1;
                        rsp_count_o <= occ_cnt;
                        if (cmd_sync_i) begin
                            chead_q <= hw_head_i;
                        end
                    end
                    OP_CLOSE: begin
                        wb_tail_o <= tail_q;
                        if (path_q == WB_MEM) begin
                            mem_wr_en_o <= 1'b1;
                        end else begin
                            reg_wr_en_o <= 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R8
    one_path_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en_o && mem_wr_en_o));

    // R8
    wb_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en_o || mem_wr_en_o) |->
            ($past(cmd_valid_i) && $past(cmd_op_i) == 3'd5 && $past(open_s) && !$past(cfg_valid_i)));

    // R4
    tail_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (rsize_q != '0) |-> (tail_q < rsize_q));

    // R5
    peek_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(accept_s) && $past(cmd_op_i) == 3'd2) |-> (tail_q == $past(tail_q)));

endmodule

// File: tb/ring_consumer_tracker_tb.sv
module ring_consumer_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_valid = 1'b0;
    logic [PW-1:0] cfg_rs = '0, cfg_es = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [31:0]   cfg_flags = '0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic          cmd_sync = 1'b0;
    logic [PW-1:0] hw_head = '0;

    logic          rsp_valid, rsp_null, err, reg_wr, mem_wr;
    logic [AW-1:0] rsp_addr;
    logic [PW-1:0] rsp_count, wb_tail;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural ring model
    int m_tail, m_head, m_rs, m_es, m_base;
    bit m_open, m_fw;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_consumer_tracker #(.PW(PW), .AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_valid_i(cfg_valid), .cfg_ring_size_i(cfg_rs), .cfg_entry_size_i(cfg_es),
        .cfg_base_i(cfg_base), .cfg_flags_i(cfg_flags),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_sync_i(cmd_sync), .hw_head_i(hw_head),
        .rsp_valid_o(rsp_valid), .rsp_null_o(rsp_null), .rsp_addr_o(rsp_addr),
        .rsp_count_o(rsp_count), .err_o(err), .reg_wr_en_o(reg_wr), .mem_wr_en_o(mem_wr),
        .wb_tail_o(wb_tail)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag, input bit e_rv, input bit e_null, input int e_addr,
                           input bit chk_cnt, input int e_cnt, input bit e_err,
                           input bit e_rwr, input bit e_mwr, input int e_wd);
        chk(tag, "rsp_valid", rsp_valid, e_rv);
        chk(tag, "rsp_null", rsp_null, e_null);
        chk(tag, "rsp_addr", rsp_addr, e_addr);
        chk(tag, "err", err, e_err);
        chk(tag, "reg_wr", reg_wr, e_rwr);
        chk(tag, "mem_wr", mem_wr, e_mwr);
        if (chk_cnt) chk(tag, "rsp_count", rsp_count, e_cnt);
        if (e_rwr || e_mwr) chk(tag, "wb_tail", wb_tail, e_wd);
    endtask

    task automatic do_cfg(input int rs, input int es, input int base, input logic [31:0] flags);
        cfg_valid = 1'b1; cfg_rs = PW'(rs); cfg_es = PW'(es);
        cfg_base = AW'(base); cfg_flags = flags;
        @(posedge clk);
        m_rs = rs; m_es = es; m_base = base; m_fw = flags[31];
        m_tail = 0; m_head = 0; m_open = 1'b0;
        @(negedge clk);
        cfg_valid = 1'b0;
        // R2
        compare("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_cmd(input string tag, input int op, input bit sync, input int hw);
        bit e_rv = 0, e_null = 0, e_err = 0, e_rwr = 0, e_mwr = 0, c_cnt = 0;
        int e_addr = 0, e_cnt = 0, e_wd = 0, nx;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_sync = sync; hw_head = PW'(hw);
        @(posedge clk);
        if (!m_open && op != 0) begin
            e_err = 1;
        end else begin
            case (op)
                0: begin m_head = hw; m_open = 1; end
                1, 2: begin
                    e_rv = 1;
                    if (m_tail != m_head) begin
                        e_addr = m_base + m_tail;
                        if (op == 1) m_tail = (m_tail + m_es) % m_rs;
                    end else e_null = 1;
                end
                3: begin
                    e_rv = 1;
                    nx = (m_head + m_es) % m_rs;
                    if (nx != m_tail) begin
                        e_addr = m_base + m_head;
                        m_head = nx;
                    end else e_null = 1;
                end
                4: begin
                    e_rv = 1; c_cnt = 1;
                    if (sync) m_head = hw;
                    if (m_head >= m_tail) e_cnt = (m_head - m_tail) / m_es;
                    else e_cnt = (m_rs - m_tail + m_head) / m_es;
                end
                5: begin
                    if (m_fw) e_mwr = 1; else e_rwr = 1;
                    e_wd = m_tail; m_open = 0;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_sync = 1'b0;
        compare(tag, e_rv, e_null, e_addr, c_cnt, e_cnt, e_err, e_rwr, e_mwr, e_wd);
    endtask

    task automatic idle(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "rsp_count", rsp_count, 0);
        chk("R1", "wb_tail", wb_tail, 0);
        compare("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: tail and head both zero -> count 0 once opened
        do_cfg(10, 3, 'h1000, 32'h0000_0000);
        // R9: commands outside a session
        do_cmd("R9", 1, 0, 0);
        do_cmd("R9", 4, 0, 0);
        do_cmd("R9", 5, 0, 0);
        // R3 open latches head
        do_cmd("R3", 0, 0, 6);
        do_cmd("R5", 2, 0, 0);
        do_cmd("R5", 2, 0, 0);
        do_cmd("R4", 1, 0, 0);
        do_cmd("R4", 1, 0, 0);
        do_cmd("R4", 1, 0, 0);          // empty -> null
        do_cmd("R7", 4, 0, 0);          // 0 entries
        do_cmd("R7", 4, 1, 2);          // resync, wrapped count
        do_cmd("R9", 6, 0, 0);          // reserved op inside session
        do_cmd("R5", 2, 0, 0);
        do_cmd("R4", 1, 0, 0);
        do_cmd("R4", 1, 0, 0);          // 9 -> 2 wrap
        do_cmd("R4", 1, 0, 0);
        do_cmd("R8", 5, 0, 0);          // register path
        idle("R10");
        do_cmd("R9", 2, 0, 0);
        // head-advancing ring with shared-memory write-back
        do_cfg(8, 2, 'h2000, 32'h8000_0000);
        do_cmd("R3", 0, 0, 0);
        do_cmd("R6", 3, 0, 0);
        do_cmd("R6", 3, 0, 0);
        do_cmd("R6", 3, 0, 0);
        do_cmd("R6", 3, 0, 0);          // full -> null
        do_cmd("R7", 4, 0, 0);
        do_cmd("R4", 1, 0, 0);
        do_cmd("R6", 3, 0, 0);          // head wraps 6 -> 0
        do_cmd("R7", 4, 0, 0);          // head < tail
        do_cmd("R3", 0, 0, 5);          // reopen inside session
        do_cmd("R7", 4, 0, 0);
        do_cmd("R8", 5, 0, 0);          // memory path
        // R2: configuration wins over a same-cycle command
        cmd_valid = 1'b1; cmd_op = 3'd0; hw_head = 16'd4;
        do_cfg(12, 4, 'h3000, 32'h0);
        cmd_valid = 1'b0;
        do_cmd("R2", 2, 0, 0);          // session closed -> err
        do_cmd("R3", 0, 0, 8);
        do_cmd("R7", 4, 0, 0);
        do_cmd("R4", 1, 0, 0);
        do_cmd("R4", 1, 0, 0);
        do_cmd("R8", 5, 0, 0);
        idle("R10");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule